// File: doc/BRIEF.md
# Handshaked Core Power-State Sequencer

This block steps a processor core through its low-power modes: Full, Doze, Nap, Sleep and Deep Sleep. Software does not ask for Doze directly. It sets a nap or a sleep request bit. Once the core reports idle, the sequencer enters Doze and raises a quiesce request to the system. The system answers on a quiesce-acknowledge input. While the acknowledge is high, the request bits select Nap or Sleep. If the acknowledge drops during Nap, the system has a snoop pending, and the sequencer falls back to Doze.

In Sleep, a PLL configuration field set to all ones takes the sequencer into Deep Sleep. There the PLL-off enable lets the system stop the reference clock. Five wake lines return any low-power mode to Full: external interrupt, SMI, soft reset, machine check and decrementer. Leaving Deep Sleep takes a fixed PLL relock interval before the core is back at Full. The hard reset is asynchronous and active low.

Top module: `pwr_mode_seq`

## Requirements
- R1: While `hrst_n` is low, the sequencer is forced at once, without waiting for a clock edge, to state code 0 (Full), with `qreq`, `clk_gate` and `pll_off` all low.
- R2: In Full (code 0), the state becomes Doze (code 1) on the next edge when `core_idle` is high and at least one of `nap_req` or `sleep_req` is high. Otherwise Full is kept, and the wake lines, `qack` and `pll_cfg` have no effect.
- R3: In Doze, with no wake line high, `qack` high, `nap_req` high and `sleep_req` low, the next state is Nap (code 2). With `qack` low, or with both request bits low, Doze is kept.
- R4: In Doze, with no wake line high, `qack` high and `sleep_req` high, the next state is Sleep (code 3), whatever the value of `nap_req`.
- R5: In Nap with no wake line high, a low `qack` returns the state to Doze on the next edge. A high `qack` keeps Nap.
- R6: In Doze, Nap or Sleep, any single high bit of `wake` (bit 0 external, 1 SMI, 2 soft reset, 3 machine check, 4 decrementer) makes the next state Full. A wake takes priority over every other transition.
- R7: In Sleep with no wake line high, the next state is Deep Sleep (code 4) only when `pll_cfg` equals 4'hF. Every other value keeps Sleep.
- R8: In Deep Sleep, a high bit of `wake` starts a relock. The state code stays 4 and `pll_off` drops to low on the next edge. The state becomes Full on the 16th edge after the edge that saw the wake. While the relock runs, further wakes and `pll_cfg` are ignored. Without a wake, Deep Sleep holds.
- R9: `qreq` is high in every state except Full. `clk_gate` is high in Nap, Sleep and Deep Sleep. `pll_off` is high only in Deep Sleep while no relock is running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core reference clock |
| hrst_n | input | 1 | Asynchronous hard reset, active low |
| nap_req | input | 1 | Software nap request bit |
| sleep_req | input | 1 | Software sleep request bit |
| core_idle | input | 1 | Core has no work in flight |
| qack | input | 1 | System quiesce acknowledge |
| wake | input | 5 | Wake lines: external, SMI, soft reset, machine check, decrementer |
| pll_cfg | input | 4 | PLL configuration field; 4'hF selects PLL off |
| pstate | output | 3 | Current state code (0 Full .. 4 Deep Sleep) |
| qreq | output | 1 | Quiesce request to the system |
| clk_gate | output | 1 | Core clock gating enable |
| pll_off | output | 1 | PLL power-down enable |

## Verification
The bench starts from each of Full, Doze, Nap and Sleep and sweeps every combination of the request bits, idle, acknowledge, each single wake line and the all-ones PLL code. A design that gave nap priority over sleep, or let a wake lose to an acknowledge transition, would land in the wrong state code. All sixteen `pll_cfg` codes are applied in Sleep, which catches a decoder that matches too broadly. Each wake line is used to leave Deep Sleep and the exit edge is counted, so an off-by-one relock counter or a `pll_off` that stays high during relock shows up. The bench also asserts reset between edges to catch a reset that waits for the clock.

// File: rtl/pwr_mode_pkg.sv
package pwr_mode_pkg;

  typedef enum logic [2:0] {
    PS_FULL  = 3'd0,
    PS_DOZE  = 3'd1,
    PS_NAP   = 3'd2,
    PS_SLEEP = 3'd3,
    PS_DEEP  = 3'd4
  } pstate_e;

  typedef struct packed {
    logic qreq;
    logic clk_gate;
    logic pll_off;
  } pctl_t;

  // Output enables as a function of the state and the relock phase.
  function automatic pctl_t decode_ctl(pstate_e s, logic relocking);
    pctl_t c;
    c.qreq     = (s != PS_FULL);
    c.clk_gate = (s == PS_NAP) || (s == PS_SLEEP) || (s == PS_DEEP);
    c.pll_off  = (s == PS_DEEP) && !relocking;
    return c;
  endfunction

endpackage

// File: rtl/pwr_wake_merge.sv
module pwr_wake_merge #(
  parameter int N_WAKE = 5
) (
  input  logic [N_WAKE-1:0] lines,
  output logic              any_wake
);
  logic [N_WAKE:0] chain;

  assign chain[0] = 1'b0;
  for (genvar i = 0; i < N_WAKE; i++) begin : g_or
    assign chain[i+1] = chain[i] | lines[i];
  end
  assign any_wake = chain[N_WAKE];
endmodule

// File: rtl/pwr_relock_cnt.sv
module pwr_relock_cnt #(
  parameter int CYCLES = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy,
  output logic done
);
  localparam int CW = (CYCLES > 2) ? $clog2(CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(CYCLES - 1);

  logic [CW-1:0] cnt;

  assign done = busy && (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (done) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (start && !busy) begin
      busy <= 1'b1;
      cnt  <= '0;
    end else if (busy) begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/pwr_state_fsm.sv
module pwr_state_fsm
  import pwr_mode_pkg::*;
#(
  parameter int            PLL_W        = 4,
  parameter logic [PLL_W-1:0] PLL_OFF_CODE = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             nap_req,
  input  logic             sleep_req,
  input  logic             core_idle,
  input  logic             qack,
  input  logic             wake,
  input  logic [PLL_W-1:0] pll_cfg,
  input  logic             relock_busy,
  input  logic             relock_done,
  output pstate_e          state,
  output logic             relock_start
);
  pstate_e nxt;
  logic    want_low;
  logic    pll_stop;

  assign want_low = (nap_req || sleep_req) && core_idle;
  assign pll_stop = (pll_cfg == PLL_OFF_CODE);

  always_comb begin
    nxt          = state;
    relock_start = 1'b0;
    unique case (state)
      PS_FULL:  if (want_low) nxt = PS_DOZE;
      PS_DOZE: begin
        if (wake)                    nxt = PS_FULL;
        else if (qack && sleep_req)  nxt = PS_SLEEP;
        else if (qack && nap_req)    nxt = PS_NAP;
      end
      PS_NAP: begin
        if (wake)       nxt = PS_FULL;
        else if (!qack) nxt = PS_DOZE;
      end
      PS_SLEEP: begin
        if (wake)          nxt = PS_FULL;
        else if (pll_stop) nxt = PS_DEEP;
      end
      PS_DEEP: begin
        if (relock_done)               nxt = PS_FULL;
        else if (wake && !relock_busy) relock_start = 1'b1;
      end
      default: nxt = PS_FULL;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= PS_FULL;
    else        state <= nxt;
  end
endmodule

// File: rtl/pwr_mode_seq.sv
module pwr_mode_seq
  import pwr_mode_pkg::*;
#(
  parameter int               N_WAKE       = 5,
  parameter int               PLL_W        = 4,
  parameter logic [PLL_W-1:0] PLL_OFF_CODE = '1,
  parameter int               RELOCK       = 16
) (
  input  logic              clk,
  input  logic              hrst_n,
  input  logic              nap_req,
  input  logic              sleep_req,
  input  logic              core_idle,
  input  logic              qack,
  input  logic [N_WAKE-1:0] wake,
  input  logic [PLL_W-1:0]  pll_cfg,
  output logic [2:0]        pstate,
  output logic              qreq,
  output logic              clk_gate,
  output logic              pll_off
);
  // Named internal events, visible to the bound checker.
  logic    wake_any;
  logic    relock_start;
  logic    relock_busy;
  logic    relock_done;
  pstate_e state;
  pctl_t   ctl;

  pwr_wake_merge #(.N_WAKE(N_WAKE)) u_wake (
    .lines    (wake),
    .any_wake (wake_any)
  );

  pwr_relock_cnt #(.CYCLES(RELOCK)) u_relock (
    .clk   (clk),
    .rst_n (hrst_n),
    .start (relock_start),
    .busy  (relock_busy),
    .done  (relock_done)
  );

  pwr_state_fsm #(.PLL_W(PLL_W), .PLL_OFF_CODE(PLL_OFF_CODE)) u_fsm (
    .clk          (clk),
    .rst_n        (hrst_n),
    .nap_req      (nap_req),
    .sleep_req    (sleep_req),
    .core_idle    (core_idle),
    .qack         (qack),
    .wake         (wake_any),
    .pll_cfg      (pll_cfg),
    .relock_busy  (relock_busy),
    .relock_done  (relock_done),
    .state        (state),
    .relock_start (relock_start)
  );

  assign ctl      = decode_ctl(state, relock_busy);
  assign pstate   = state;
  assign qreq     = ctl.qreq;
  assign clk_gate = ctl.clk_gate;
  assign pll_off  = ctl.pll_off;
endmodule

// File: rtl/pwr_mode_seq_chk.sv
module pwr_mode_seq_chk #(
  parameter int               PLL_W        = 4,
  parameter logic [PLL_W-1:0] PLL_OFF_CODE = '1,
  parameter int               RELOCK       = 16
) (
  input logic             clk,
  input logic             hrst_n,
  input logic             nap_req,
  input logic             sleep_req,
  input logic             core_idle,
  input logic             qack,
  input logic             wake_any,
  input logic [PLL_W-1:0] pll_cfg,
  input logic [2:0]       pstate,
  input logic             qreq,
  input logic             clk_gate,
  input logic             pll_off,
  input logic             relock_busy
);
  localparam int BW = $clog2(RELOCK + 1) + 1;
  logic [BW-1:0] busy_cycles;

  always_ff @(posedge clk or negedge hrst_n) begin
    if (!hrst_n)          busy_cycles <= '0;
    else if (relock_busy) busy_cycles <= busy_cycles + 1'b1;
    else                  busy_cycles <= '0;
  end

  // R2
  doze_entry_chk: assert property (@(posedge clk) disable iff (!hrst_n)
    (pstate == 3'd0 && (nap_req || sleep_req) && core_idle) |=> pstate == 3'd1);

  // R3
  nap_entry_chk: assert property (@(posedge clk) disable iff (!hrst_n)
    (pstate == 3'd1 && !wake_any && qack && nap_req && !sleep_req) |=> pstate == 3'd2);

  // R4
  sleep_prio_chk: assert property (@(posedge clk) disable iff (!hrst_n)
    (pstate == 3'd1 && !wake_any && qack && sleep_req) |=> pstate == 3'd3);

  // R5
  snoop_fallback_chk: assert property (@(posedge clk) disable iff (!hrst_n)
    (pstate == 3'd2 && !wake_any && !qack) |=> pstate == 3'd1);

  // R6
  wake_exit_chk: assert property (@(posedge clk) disable iff (!hrst_n)
    (pstate inside {3'd1, 3'd2, 3'd3} && wake_any) |=> pstate == 3'd0);

  // R7
  deep_entry_chk: assert property (@(posedge clk) disable iff (!hrst_n)
    (pstate == 3'd3 && !wake_any && pll_cfg == PLL_OFF_CODE) |=> pstate == 3'd4);

  // R8
  relock_len_chk: assert property (@(posedge clk) disable iff (!hrst_n)
    (pstate == 3'd0 && $past(pstate) == 3'd4) |-> busy_cycles == BW'(RELOCK));

  // R8
  relock_pll_chk: assert property (@(posedge clk) disable iff (!hrst_n)
    relock_busy |-> (pstate == 3'd4 && !pll_off));

  // R9
  gate_needs_qreq_chk: assert property (@(posedge clk) disable iff (!hrst_n)
    clk_gate |-> qreq);

  // R9
  pll_off_deep_chk: assert property (@(posedge clk) disable iff (!hrst_n)
    pll_off |-> (pstate == 3'd4 && clk_gate));

  // R9
  full_quiet_chk: assert property (@(posedge clk) disable iff (!hrst_n)
    (pstate == 3'd0) |-> (!qreq && !clk_gate && !pll_off));
endmodule

bind pwr_mode_seq pwr_mode_seq_chk #(
  .PLL_W(PLL_W), .PLL_OFF_CODE(PLL_OFF_CODE), .RELOCK(RELOCK)
) u_chk (
  .clk         (clk),
  .hrst_n      (hrst_n),
  .nap_req     (nap_req),
  .sleep_req   (sleep_req),
  .core_idle   (core_idle),
  .qack        (qack),
  .wake_any    (wake_any),
  .pll_cfg     (pll_cfg),
  .pstate      (pstate),
  .qreq        (qreq),
  .clk_gate    (clk_gate),
  .pll_off     (pll_off),
  .relock_busy (relock_busy)
);

// File: tb/tb_pwr_mode_seq.sv
`timescale 1ns/1ps
module tb_pwr_mode_seq;
  logic       clk = 1'b0;
  logic       hrst_n;
  logic       nap_req, sleep_req, core_idle, qack;
  logic [4:0] wake;
  logic [3:0] pll_cfg;
  logic [2:0] pstate;
  logic       qreq, clk_gate, pll_off;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  pwr_mode_seq dut (
    .clk(clk), .hrst_n(hrst_n), .nap_req(nap_req), .sleep_req(sleep_req),
    .core_idle(core_idle), .qack(qack), .wake(wake), .pll_cfg(pll_cfg),
    .pstate(pstate), .qreq(qreq), .clk_gate(clk_gate), .pll_off(pll_off)
  );

  // Expected {pstate, qreq, clk_gate, pll_off} for a settled state (no relock).
  function automatic logic [5:0] view(input logic [2:0] s);
    return {s, s != 3'd0, s >= 3'd2, s == 3'd4};
  endfunction

  function automatic logic [2:0] expect_next(input logic [2:0] s, input logic n,
      input logic sl, input logic id, input logic q, input logic w, input logic pf);
    case (s)
      3'd0:    return ((n | sl) & id) ? 3'd1 : 3'd0;
      3'd1:    return w ? 3'd0 : (q & sl) ? 3'd3 : (q & n) ? 3'd2 : 3'd1;
      3'd2:    return w ? 3'd0 : !q ? 3'd1 : 3'd2;
      3'd3:    return w ? 3'd0 : pf ? 3'd4 : 3'd3;
      default: return s;
    endcase
  endfunction

  function automatic string tag_for(input logic [2:0] s, input logic w, input logic sl);
    if (s == 3'd0) return "R2";
    if (w) return "R6";
    if (s == 3'd1) return sl ? "R4" : "R3";
    if (s == 3'd2) return "R5";
    return "R7";
  endfunction

  task automatic check(input string req, input logic [5:0] act, input logic [5:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got state=%0d q=%b g=%b p=%b, expected state=%0d q=%b g=%b p=%b",
               req, act[5:3], act[2], act[1], act[0], exp[5:3], exp[2], exp[1], exp[0]);
    end
  endtask

  function automatic logic [5:0] outs();
    return {pstate, qreq, clk_gate, pll_off};
  endfunction

  task automatic drive(input logic n, input logic sl, input logic id, input logic q,
                       input logic [4:0] w, input logic [3:0] pc);
    nap_req = n; sleep_req = sl; core_idle = id; qack = q; wake = w; pll_cfg = pc;
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic do_reset();
    @(negedge clk);
    drive(0, 0, 0, 0, 5'd0, 4'd0);
    hrst_n = 1'b0;
    tick();
    @(negedge clk);
    hrst_n = 1'b1;
  endtask

  // Reach a state from reset by the legal path; inputs are driven at negedges.
  task automatic goto_state(input logic [2:0] target);
    do_reset();
    if (target >= 3'd1) begin drive(1, 0, 1, 0, 5'd0, 4'd0); tick(); @(negedge clk); end
    if (target == 3'd2) begin drive(1, 0, 1, 1, 5'd0, 4'd0); tick(); @(negedge clk); end
    if (target >= 3'd3) begin drive(0, 1, 1, 1, 5'd0, 4'd0); tick(); @(negedge clk); end
    if (target == 3'd4) begin drive(0, 1, 1, 1, 5'd0, 4'hF); tick(); @(negedge clk); end
  endtask

  initial begin
    hrst_n = 1'b0;
    drive(0, 0, 0, 0, 5'd0, 4'd0);
    repeat (2) tick();
    // R1: reset state
    check("R1", outs(), view(3'd0));

    // R2..R7, R9: sweep every start state against every input combination.
    for (int s = 0; s < 4; s++) begin
      for (int combo = 0; combo < 16; combo++) begin
        for (int wi = 0; wi < 6; wi++) begin
          for (int pf = 0; pf < 2; pf++) begin
            logic [4:0] wv;
            logic [2:0] exp_s;
            wv = (wi == 5) ? 5'd0 : 5'(1 << wi);
            goto_state(3'(s));
            check("R9", outs(), view(3'(s)));
            drive(combo[0], combo[1], combo[2], combo[3], wv, pf ? 4'hF : 4'h0);
            exp_s = expect_next(3'(s), combo[0], combo[1], combo[2], combo[3],
                                wv != 0, pf[0]);
            tick();
            check(tag_for(3'(s), wv != 0, combo[1]), outs(), view(exp_s));
          end
        end
      end
    end

    // R7: only code 4'hF enters Deep Sleep from Sleep.
    for (int pc = 0; pc < 16; pc++) begin
      goto_state(3'd3);
      drive(0, 1, 1, 1, 5'd0, 4'(pc));
      tick();
      check("R7", outs(), view(pc == 15 ? 3'd4 : 3'd3));
    end

    // R8: Deep Sleep holds without a wake, whatever the other inputs do.
    goto_state(3'd4);
    for (int i = 0; i < 40; i++) begin
      drive(i[0], i[1], i[2], i[3], 5'd0, 4'(i));
      tick();
      @(negedge clk);
    end
    check("R8", outs(), view(3'd4));

    // R8: relock length and pll_off release for each wake line, pulsed or held.
    for (int wi = 0; wi < 5; wi++) begin
      for (int hold = 0; hold < 2; hold++) begin
        goto_state(3'd4);
        drive(0, 0, 0, 0, 5'(1 << wi), 4'h3);
        tick();
        check("R8", outs(), {3'd4, 1'b1, 1'b1, 1'b0});
        for (int k = 1; k < 16; k++) begin
          @(negedge clk);
          drive(0, 0, 0, 0, hold ? 5'(1 << wi) : 5'd0, 4'hF);
          tick();
          check("R8", outs(), {3'd4, 1'b1, 1'b1, 1'b0});
        end
        tick();
        check("R8", outs(), view(3'd0));
      end
    end

    // R1: reset applied between edges takes effect at once.
    goto_state(3'd3);
    #1 hrst_n = 1'b0;
    #1 check("R1", outs(), view(3'd0));
    hrst_n = 1'b1;

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got run still going, expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule